// File: doc/BRIEF.md
# Event-Matched Programmable Pulse Generator

This block is the trigger generator on the receive side of a timing client. It takes in a stream of decoded 16-bit timing words, one per clock. The upper byte of each word is an event code. The block looks that code up in a mapping table of 256 entries, one entry per code, which the host writes. Each entry holds one enable bit per output channel.

Every channel whose bit is set starts its own delay count. When the delay has run out, the channel drives a pulse. Each channel has its own delay, width, polarity and enable. With one count per 8 ns clock, the 32-bit delay spans more than half a minute and the 16-bit width spans about half a millisecond.

The word stream uses a valid/ready handshake. A word is taken on a clock edge where both `in_valid` and `in_ready` are high. The block never applies back-pressure: `in_ready` is low while reset is applied and high on every cycle after the first edge out of reset. A source may therefore hold data without stalling, but anything it offers while `in_ready` is low is dropped. The mapping table is written one entry at a time through an address/data port. All settings of one channel are written together in a single cycle.

Top module: `evt_pulse_gen`

## Requirements
- R1: While `rst` is high and on the first edge after it, `in_ready` is 0. On that first edge `in_ready` becomes 1. Reset clears every mapping entry, disables every channel, and drives `trig_out` and `overlap` to all zeros.
- R2: Only bits [15:8] of `in_word` form the event code. Bits [7:0] have no effect. Bit i of the mapping entry for a code selects channel i.
- R3: When a code is accepted on edge E for an idle, enabled channel whose delay is 0, that output is active on the cycle right after edge E.
- R4: When the delay is d > 0, the output becomes active after edge E+d.
- R5: The output stays active for w cycles and then returns to its inactive level. A width setting of 0 acts as 1.
- R6: `chan_pol`=0 makes the channel active-high (idle 0). `chan_pol`=1 makes it active-low (idle 1).
- R7: A channel is busy from the edge after acceptance up to and including the edge on which its pulse ends. A matching code accepted while the channel is busy does not restart it, and sets that channel's sticky `overlap` bit.
- R8: Event code 0x00 never starts a channel and never sets an overlap bit, whatever its mapping entry holds.
- R9: A disabled channel (`chan_en`=0) holds its output at its inactive level. It ignores matching codes and does not set its overlap bit.
- R10: A channel write (`chan_we` with `chan_sel`=i) loads the new settings, returns channel i to idle, and clears `overlap[i]`. A code that matches channel i on the same edge is ignored by channel i.
- R11: A mapping write on edge E applies to codes accepted from edge E+1 onward. A code accepted on edge E itself uses the previous entry.
- R12: Channels run independently. One code can start several channels, each with its own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one count per period |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Timing word offered |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| in_word | input | 16 | Timing word; event code in [15:8] |
| map_we | input | 1 | Write one mapping entry |
| map_addr | input | 8 | Event code whose entry is written |
| map_wdata | input | 14 | Channel enable bits for that code |
| chan_we | input | 1 | Write all settings of one channel |
| chan_sel | input | 4 | Channel written (0..13) |
| chan_delay | input | 32 | Delay in clock cycles |
| chan_width | input | 16 | Pulse width in clock cycles (0 acts as 1) |
| chan_pol | input | 1 | 1 = active-low output |
| chan_en | input | 1 | 1 = channel enabled |
| trig_out | output | 14 | Trigger outputs, one per channel |
| overlap | output | 14 | Sticky flags for matches while busy |

## Verification
The bench keeps a schedule-based model: each channel stores only the edges at which its pulse starts and ends. The RTL's outputs are compared against that model on every cycle.

The stimulus targets these edges of the behaviour:
- A zero delay and a zero width. A design off by one cycle would shift the pulse or lengthen it.
- A retrigger on the last pulse cycle and codes sent back to back. A design that restarts the pulse, or misses the overlap flag, would stretch the output.
- Code 0x00 with an entry of all ones. A design without the guard would fire every channel.
- A channel write and a mapping write landing on the same edge as a match. A design that reads the new entry early, or lets the match win over the write, would show a pulse the model does not expect.
- A disabled active-low channel. It must sit high and ignore its code.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int CODE_W = 8;
  localparam int WORD_W = 16;
  localparam int NCH    = 14;
  localparam int DLY_W  = 32;
  localparam int WID_W  = 16;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_DELAY = 2'd1,
    CH_PULSE = 2'd2
  } ch_state_e;
endpackage

// File: rtl/evt_map_ram.sv
module evt_map_ram #(
  parameter int NCH    = 14,
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [NCH-1:0]    wdata,
  input  logic [CODE_W-1:0] raddr,
  output logic [NCH-1:0]    rdata
);
  localparam int DEPTH = 1 << CODE_W;

  logic [NCH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // Code zero is reserved: it never selects any channel.
  always_comb begin
    if (raddr == '0) rdata = '0;
    else             rdata = mem[raddr];
  end
endmodule

// File: rtl/evt_pulse_chan.sv
module evt_pulse_chan
  import evt_pkg::*;
#(
  parameter int DLY_W = 32,
  parameter int WID_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [WID_W-1:0] cfg_width,
  input  logic             cfg_pol,
  input  logic             cfg_en,
  input  logic             fire,
  output logic             trig,
  output logic             ovl
);
  ch_state_e        st;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] delay_q;
  logic [WID_W-1:0] width_q;
  logic             pol_q;
  logic             en_q;
  logic             ovl_q;
  logic             busy;
  logic [DLY_W-1:0] wload;

  assign busy  = (st != CH_IDLE);
  assign wload = (width_q == '0) ? DLY_W'(1) : DLY_W'(width_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CH_IDLE;
      cnt     <= '0;
      delay_q <= '0;
      width_q <= '0;
      pol_q   <= 1'b0;
      en_q    <= 1'b0;
      ovl_q   <= 1'b0;
    end else if (cfg_we) begin
      st      <= CH_IDLE;
      cnt     <= '0;
      delay_q <= cfg_delay;
      width_q <= cfg_width;
      pol_q   <= cfg_pol;
      en_q    <= cfg_en;
      ovl_q   <= 1'b0;
    end else begin
      unique case (st)
        CH_IDLE: begin
          if (fire && en_q) begin
            if (delay_q == '0) begin
              st  <= CH_PULSE;
              cnt <= wload;
            end else begin
              st  <= CH_DELAY;
              cnt <= delay_q;
            end
          end
        end
        CH_DELAY: begin
          if (cnt == DLY_W'(1)) begin
            st  <= CH_PULSE;
            cnt <= wload;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        CH_PULSE: begin
          if (cnt == DLY_W'(1)) st <= CH_IDLE;
          else                  cnt <= cnt - 1'b1;
        end
        default: st <= CH_IDLE;
      endcase
      if (fire && en_q && busy) ovl_q <= 1'b1;
    end
  end

  assign trig = en_q ? ((st == CH_PULSE) ^ pol_q) : pol_q;
  assign ovl  = ovl_q;

  // R3
  zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && fire && en_q && !busy && delay_q == '0) |=> (trig == !pol_q));
  // R7
  overlap_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && fire && en_q && busy) |=> ovl);
  // R5
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && st == CH_PULSE && cnt == DLY_W'(1)) |=> (trig == pol_q));
  // R9
  disabled_level_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (trig == pol_q));
  // R10
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!ovl && !busy));
endmodule

// File: rtl/evt_pulse_gen.sv
module evt_pulse_gen
  import evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              map_we,
  input  logic [CODE_W-1:0] map_addr,
  input  logic [NCH-1:0]    map_wdata,
  input  logic              chan_we,
  input  logic [3:0]        chan_sel,
  input  logic [DLY_W-1:0]  chan_delay,
  input  logic [WID_W-1:0]  chan_width,
  input  logic              chan_pol,
  input  logic              chan_en,
  output logic [NCH-1:0]    trig_out,
  output logic [NCH-1:0]    overlap
);
  localparam int SEL_W = 4;

  logic              ready_q;
  logic [CODE_W-1:0] code;
  logic [NCH-1:0]    map_hit;
  logic              accept;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign code     = in_word[WORD_W-1 -: CODE_W];
  assign accept   = in_valid && ready_q;

  evt_map_ram #(.NCH(NCH), .CODE_W(CODE_W)) u_map (
    .clk   (clk),
    .rst   (rst),
    .we    (map_we),
    .waddr (map_addr),
    .wdata (map_wdata),
    .raddr (code),
    .rdata (map_hit)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel_we;
    assign sel_we = chan_we && (chan_sel == SEL_W'(i));

    evt_pulse_chan #(.DLY_W(DLY_W), .WID_W(WID_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (sel_we),
      .cfg_delay (chan_delay),
      .cfg_width (chan_width),
      .cfg_pol   (chan_pol),
      .cfg_en    (chan_en),
      .fire      (accept && map_hit[i]),
      .trig      (trig_out[i]),
      .ovl       (overlap[i])
    );
  end

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);
  // R8
  code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && code == '0) |-> (map_hit == '0));
endmodule

// File: tb/test_evt_pulse_gen.sv
module test_evt_pulse_gen;
  localparam int N = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        map_we = 1'b0;
  logic [7:0]  map_addr = '0;
  logic [13:0] map_wdata = '0;
  logic        chan_we = 1'b0;
  logic [3:0]  chan_sel = '0;
  logic [31:0] chan_delay = '0;
  logic [15:0] chan_width = '0;
  logic        chan_pol = 1'b0;
  logic        chan_en = 1'b0;
  logic [13:0] trig_out;
  logic [13:0] overlap;

  always #4 clk = ~clk;

  evt_pulse_gen i_evt_pulse_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .map_we(map_we), .map_addr(map_addr),
    .map_wdata(map_wdata), .chan_we(chan_we), .chan_sel(chan_sel),
    .chan_delay(chan_delay), .chan_width(chan_width), .chan_pol(chan_pol),
    .chan_en(chan_en), .trig_out(trig_out), .overlap(overlap)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "R1 reset";

  // Behavioural model: each channel keeps the edges where its pulse starts and ends.
  logic [13:0] m_map [256];
  longint      m_start [N];
  longint      m_end   [N];
  longint      m_dly   [N];
  longint      m_wid   [N];
  bit          m_en    [N];
  bit          m_pol   [N];
  bit          m_ovl   [N];
  bit          m_rdy;
  longint      e;

  always @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < 256; a++) m_map[a] = '0;
      for (int c = 0; c < N; c++) begin
        m_start[c] = 0; m_end[c] = -1; m_dly[c] = 0; m_wid[c] = 0;
        m_en[c] = 0; m_pol[c] = 0; m_ovl[c] = 0;
      end
      m_rdy = 0;
      e = 0;
    end else begin
      e++;
      if (in_valid && m_rdy && in_word[15:8] != 8'h00) begin
        for (int c = 0; c < N; c++) begin
          if (m_map[in_word[15:8]][c] && !(chan_we && chan_sel == c) && m_en[c]) begin
            if (e <= m_end[c]) m_ovl[c] = 1;
            else begin
              m_start[c] = e + m_dly[c];
              m_end[c]   = e + m_dly[c] + ((m_wid[c] == 0) ? 1 : m_wid[c]);
            end
          end
        end
      end
      if (chan_we && chan_sel < N) begin
        m_dly[chan_sel] = chan_delay;
        m_wid[chan_sel] = chan_width;
        m_pol[chan_sel] = chan_pol;
        m_en[chan_sel]  = chan_en;
        m_end[chan_sel] = -1;
        m_ovl[chan_sel] = 0;
      end
      if (map_we) m_map[map_addr] = map_wdata;
      m_rdy = 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at edge %0d", tag, act, exp, e);
    end
  endtask

  always @(negedge clk) begin
    logic [13:0] xt, xo;
    for (int c = 0; c < N; c++) begin
      bit act;
      act   = (m_start[c] <= e) && (e < m_end[c]);
      xt[c] = m_en[c] ? (act ^ m_pol[c]) : m_pol[c];
      xo[c] = m_ovl[c];
    end
    chk({phase, " trig_out"}, trig_out, xt);
    chk({phase, " overlap"}, overlap, xo);
    chk({phase, " in_ready"}, in_ready, m_rdy);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] code, input logic [7:0] lo);
    @(negedge clk);
    in_valid = 1'b1; in_word = {code, lo};
    @(negedge clk);
    in_valid = 1'b0; in_word = '0;
  endtask

  task automatic map_wr(input logic [7:0] a, input logic [13:0] d);
    @(negedge clk);
    map_we = 1'b1; map_addr = a; map_wdata = d;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic cfg(input int ch, input int d, input int w, input bit p, input bit en);
    @(negedge clk);
    chan_we = 1'b1; chan_sel = 4'(ch); chan_delay = 32'(d);
    chan_width = 16'(w); chan_pol = p; chan_en = en;
    @(negedge clk);
    chan_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    phase = "R1 reset";
    idle(4);
    rst = 1'b0;
    idle(2);

    phase = "R11 map setup";
    map_wr(8'h10, 14'h0001);
    map_wr(8'h20, 14'h0006);
    map_wr(8'h00, 14'h3fff);
    map_wr(8'h30, 14'h0008);
    map_wr(8'h40, 14'h0010);
    map_wr(8'h50, 14'h3fff);
    map_wr(8'h60, 14'h0020);
    cfg(0, 0, 3, 0, 1);
    cfg(1, 5, 0, 1, 1);
    cfg(2, 40, 4, 0, 1);
    cfg(3, 0, 2, 1, 0);
    cfg(4, 2, 2, 0, 1);
    idle(2);

    phase = "R3 zero delay";
    send(8'h10, 8'h00); idle(6);

    phase = "R4 R5 R6 delay width polarity";
    send(8'h20, 8'h55); idle(60);

    phase = "R2 low byte ignored";
    send(8'h40, 8'h00); idle(6);
    send(8'h40, 8'hff); idle(6);
    send(8'h41, 8'h40); idle(6);

    phase = "R7 overlap while busy";
    send(8'h10, 8'h00); send(8'h10, 8'h00); idle(6);
    send(8'h10, 8'h00); idle(1); send(8'h10, 8'h00); idle(6);
    @(negedge clk); in_valid = 1'b1; in_word = 16'h4000;
    idle(8); in_valid = 1'b0; in_word = '0; idle(6);

    phase = "R10 config clears";
    cfg(0, 0, 3, 0, 1); idle(3);
    send(8'h10, 8'h00);
    @(negedge clk); chan_we = 1'b1; chan_sel = 4'd0; chan_delay = 32'd1;
    chan_width = 16'd2; chan_pol = 1'b0; chan_en = 1'b1;
    in_valid = 1'b1; in_word = 16'h1000;
    @(negedge clk); chan_we = 1'b0; in_valid = 1'b0; in_word = '0;
    idle(6);

    phase = "R8 code zero";
    send(8'h00, 8'h10); idle(6);

    phase = "R9 disabled";
    send(8'h30, 8'h00); idle(5);
    cfg(3, 0, 2, 1, 1);
    send(8'h30, 8'h00); idle(5);

    phase = "R11 same-edge map write";
    @(negedge clk); map_we = 1'b1; map_addr = 8'h70; map_wdata = 14'h0001;
    in_valid = 1'b1; in_word = 16'h7000;
    @(negedge clk); map_we = 1'b0; in_valid = 1'b0; in_word = '0;
    idle(6);
    send(8'h70, 8'h00); idle(6);

    phase = "R12 independent channels";
    send(8'h50, 8'h00); idle(60);
    cfg(5, 1000, 10, 0, 1);
    send(8'h60, 8'h00); idle(1020);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule